// File: doc/BRIEF.md
# Abstract Register-Access Command Sequencer

This block sits inside a debug controller and turns one abstract register-access command into the two instruction words that a halted hart runs from the debug memory window. The command carries a register number, an access size, and three flags: transfer, write and postexec. The block builds either a load or a store that moves a general-purpose register through the data word at address 0x400 relative to x0, or a nop when no transfer is asked for. The second word is either a nop, which lets execution fall through into the debugger's own program buffer, or an ebreak, which sends the hart straight back to its park loop.

An accepted command produces a one-cycle start pulse toward the hart and raises busy. Busy stays high until the hart reports that it has returned to the park loop. The hart has already ordered its side effects with a fence by then. Exceptions reported by the hart, commands issued while busy, and commands that cannot be encoded set a sticky command-error code. The debugger clears that code explicitly.

Top module: `arsq_seq`

## Requirements
- R1: After reset, busy_o=0, go_o=0, cmderr_o=0, insn0_o=0x00000013 (nop) and insn1_o=0x00100073 (ebreak).
- R2: A transfer with write=1 produces a load into GPR regno[4:0] from 0x400(x0): I-type {imm=0x400, rs1=0, funct3, rd, opcode}.
- R3: A transfer with write=0 produces a store of GPR regno[4:0] to 0x400(x0): S-type {imm[11:5]=0x20, rs2, rs1=0, funct3, imm[4:0]=0, opcode}.
- R4: size 2 selects 32-bit access: lw (opcode 0x03, funct3 2) or sw (opcode 0x23, funct3 2). Size 3 selects 64-bit: ld (0x03, 3) or sd (0x23, 3). Size 4 selects 128-bit: lq (opcode 0x0F, funct3 2) or sq (0x23, 4). A size below 2 or above MAX_SIZE is unsupported.
- R5: With transfer=0, insn0_o is a nop (0x00000013), and regno and size are not checked.
- R6: insn1_o is a nop when postexec=1 and an ebreak (0x00100073) when postexec=0.
- R7: A command is accepted when cmd_valid_i is high, busy_o=0 and cmderr_o=0, and it is supported. On the next cycle, go_o pulses for one cycle, busy_o=1 and the new words appear on insn0_o/insn1_o.
- R8: busy_o stays 1 until the cycle after hart_done_i is sampled high.
- R9: A command while busy_o=1 is ignored (no go_o, words unchanged), and cmderr_o becomes 1 if it was 0.
- R10: With transfer=1, a regno outside 0x1000..0x101F or an unsupported size sets cmderr_o to 2, with no go_o and busy_o left at 0.
- R11: hart_exc_i sampled while busy sets cmderr_o to 3 if it was 0. busy_o still waits for hart_done_i.
- R12: cmderr_o only changes from 0 to non-zero, or to 0 on err_clr_i. Clear wins over a new error in the same cycle. Commands are ignored while cmderr_o is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_regno_i | input | 16 | Register number |
| cmd_size_i | input | 3 | Access size (log2 of bytes... 2=32, 3=64, 4=128 bit) |
| cmd_transfer_i | input | 1 | Perform register transfer |
| cmd_write_i | input | 1 | 1: data word to register, 0: register to data word |
| cmd_postexec_i | input | 1 | Continue into program buffer after transfer |
| err_clr_i | input | 1 | Clear command error |
| hart_done_i | input | 1 | Hart back in park loop |
| hart_exc_i | input | 1 | Hart reported an exception |
| busy_o | output | 1 | Command in progress |
| go_o | output | 1 | One-cycle start pulse to hart |
| cmderr_o | output | 3 | Sticky command error (0 none, 1 busy, 2 unsupported, 3 exception) |
| insn0_o | output | 32 | Transfer slot word |
| insn1_o | output | 32 | Slot after transfer |

## Verification
On every cycle, the assertions check the protocol invariants. A start pulse only comes with a rising busy. Busy only falls after a done. Error codes are sticky. A command while busy raises code 1. An unsupported command neither starts the hart nor sets busy. The second word is always a nop or an ebreak. Only the bench scenarios show that the instruction encodings are correct for each size, direction and register. They also cover the exception path and the ignored-while-error behaviour.

// File: rtl/arsq_pkg.sv
package arsq_pkg;
  localparam logic [31:0] INSN_NOP    = 32'h0000_0013;
  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;
  localparam logic [11:0] XFER_OFS    = 12'h400;
  localparam logic [15:0] GPR_BASE    = 16'h1000;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_BUSY   = 3'd1,
    ERR_NOTSUP = 3'd2,
    ERR_EXC    = 3'd3
  } cmderr_e;

  function automatic logic [31:0] enc_load(input logic [2:0] f3, input logic [6:0] op,
                                           input logic [4:0] rd);
    return {XFER_OFS, 5'd0, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_store(input logic [2:0] f3, input logic [4:0] rs2);
    return {XFER_OFS[11:5], rs2, 5'd0, f3, XFER_OFS[4:0], 7'h23};
  endfunction
endpackage

// File: rtl/arsq_encoder.sv
module arsq_encoder
  import arsq_pkg::*;
#(
  parameter int MAX_SIZE = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [15:0] regno_i,
  input  logic [2:0]  size_i,
  input  logic        transfer_i,
  input  logic        write_i,
  input  logic        postexec_i,
  output logic        supported_o,
  output logic [31:0] insn0_o,
  output logic [31:0] insn1_o
);
  localparam logic [2:0] MAX_SZ = 3'(MAX_SIZE);

  logic        size_ok, reg_ok;
  logic [31:0] xfer_word, nxt0, nxt1;
  logic [31:0] insn0_q, insn1_q;

  assign size_ok = (size_i >= 3'd2) && (size_i <= MAX_SZ);
  assign reg_ok  = (regno_i[15:5] == GPR_BASE[15:5]);
  assign supported_o = !transfer_i || (size_ok && reg_ok);

  always_comb begin
    xfer_word = INSN_NOP;
    unique case (size_i)
      3'd2:    xfer_word = write_i ? enc_load(3'd2, 7'h03, regno_i[4:0])
                                   : enc_store(3'd2, regno_i[4:0]);
      3'd3:    xfer_word = write_i ? enc_load(3'd3, 7'h03, regno_i[4:0])
                                   : enc_store(3'd3, regno_i[4:0]);
      3'd4:    xfer_word = write_i ? enc_load(3'd2, 7'h0F, regno_i[4:0])
                                   : enc_store(3'd4, regno_i[4:0]);
      default: xfer_word = INSN_NOP;
    endcase
    nxt0 = transfer_i ? xfer_word : INSN_NOP;
    nxt1 = postexec_i ? INSN_NOP : INSN_EBREAK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insn0_q <= INSN_NOP;
      insn1_q <= INSN_EBREAK;
    end else if (load_i) begin
      insn0_q <= nxt0;
      insn1_q <= nxt1;
    end
  end

  assign insn0_o = insn0_q;
  assign insn1_o = insn1_q;

  // R6: tail slot only ever holds a fall-through nop or an ebreak
  always_comb begin
    if (rst_ni) a_r6_tail_word: assert (insn1_q == INSN_NOP || insn1_q == INSN_EBREAK);
  end

  // R9: words are frozen while no command is loaded
  a_r9_words_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(insn0_q) && $stable(insn1_q));
endmodule

// File: rtl/arsq_ctrl.sv
module arsq_ctrl
  import arsq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic       supported_i,
  input  logic       err_clr_i,
  input  logic       hart_done_i,
  input  logic       hart_exc_i,
  output logic       accept_o,
  output logic       busy_o,
  output logic       go_o,
  output logic [2:0] cmderr_o
);
  logic    busy_q, go_q;
  cmderr_e err_q, err_new;

  assign accept_o = cmd_valid_i && !busy_q && (err_q == ERR_NONE) && supported_i;

  always_comb begin
    err_new = ERR_NONE;
    if (busy_q && cmd_valid_i)                       err_new = ERR_BUSY;
    else if (cmd_valid_i && !busy_q && !supported_i) err_new = ERR_NOTSUP;
    else if (busy_q && hart_exc_i)                   err_new = ERR_EXC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      go_q   <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      go_q <= accept_o;
      if (accept_o)                 busy_q <= 1'b1;
      else if (busy_q && hart_done_i) busy_q <= 1'b0;
      if (err_clr_i)                err_q <= ERR_NONE;
      else if (err_q == ERR_NONE)   err_q <= err_new;
    end
  end

  assign busy_o   = busy_q;
  assign go_o     = go_q;
  assign cmderr_o = err_q;

  // R7: start pulse only on the cycle busy rises
  a_r7_go_with_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q |-> busy_q && $past(!busy_q));
  // R8: busy cannot drop without a done from the hart
  a_r8_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !hart_done_i |=> busy_q);
  // R9: a command while busy flags the busy error
  a_r9_busy_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cmd_valid_i && err_q == ERR_NONE && !err_clr_i |=> err_q == ERR_BUSY);
  // R12: error code is sticky until cleared
  a_r12_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q != ERR_NONE && !err_clr_i |=> err_q == $past(err_q));
endmodule

// File: rtl/arsq_seq.sv
module arsq_seq
  import arsq_pkg::*;
#(
  parameter int MAX_SIZE = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [15:0] cmd_regno_i,
  input  logic [2:0]  cmd_size_i,
  input  logic        cmd_transfer_i,
  input  logic        cmd_write_i,
  input  logic        cmd_postexec_i,
  input  logic        err_clr_i,
  input  logic        hart_done_i,
  input  logic        hart_exc_i,
  output logic        busy_o,
  output logic        go_o,
  output logic [2:0]  cmderr_o,
  output logic [31:0] insn0_o,
  output logic [31:0] insn1_o
);
  logic supported, accept;

  arsq_encoder #(.MAX_SIZE(MAX_SIZE)) u_enc (
    .clk_i, .rst_ni,
    .load_i(accept),
    .regno_i(cmd_regno_i), .size_i(cmd_size_i),
    .transfer_i(cmd_transfer_i), .write_i(cmd_write_i), .postexec_i(cmd_postexec_i),
    .supported_o(supported),
    .insn0_o, .insn1_o
  );

  arsq_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .cmd_valid_i, .supported_i(supported),
    .err_clr_i, .hart_done_i, .hart_exc_i,
    .accept_o(accept),
    .busy_o, .go_o, .cmderr_o
  );

  // R10: an unencodable command never starts the hart
  a_r10_notsup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !busy_o && cmderr_o == 3'd0 && !supported && !err_clr_i
    |=> !go_o && !busy_o && cmderr_o == 3'd2);
endmodule

// File: tb/tb_arsq_seq.sv
module tb_arsq_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, tr = 0, wr = 0, pe = 0, clr = 0, done = 0, exc = 0;
  logic [15:0] regno = 0;
  logic [2:0]  size = 0;
  logic busy, go;
  logic [2:0] cmderr;
  logic [31:0] i0, i1;
  int n_chk = 0, n_fail = 0;
  logic [63:0] sb_q[$];

  always #4 clk = ~clk;

  arsq_seq #(.MAX_SIZE(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_regno_i(regno),
    .cmd_size_i(size), .cmd_transfer_i(tr), .cmd_write_i(wr), .cmd_postexec_i(pe),
    .err_clr_i(clr), .hart_done_i(done), .hart_exc_i(exc),
    .busy_o(busy), .go_o(go), .cmderr_o(cmderr), .insn0_o(i0), .insn1_o(i1));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_xfer(input logic [4:0] r, input logic [2:0] sz, input bit w);
    logic [6:0] op; logic [2:0] f;
    if (w) begin
      op = (sz == 3'd4) ? 7'b0001111 : 7'b0000011;
      f  = (sz == 3'd3) ? 3'b011 : 3'b010;
      return {12'h400, 5'd0, f, r, op};
    end
    f = (sz == 3'd2) ? 3'b010 : (sz == 3'd3) ? 3'b011 : 3'b100;
    return {7'b0100000, r, 5'd0, f, 5'b00000, 7'b0100011};
  endfunction

  // monitor: every start pulse must match the next expected pair
  always @(negedge clk) if (rst_n && go) begin
    if (sb_q.size() == 0) chk(0, "R7 unexpected go", {i0, i1}, 64'h0);
    else begin
      logic [63:0] e;
      e = sb_q.pop_front();
      chk({i0, i1} == e, "R2/R3/R4/R5/R6 words", {i0, i1}, e);
      chk(busy, "R7 busy with go", busy, 1);
    end
  end

  task automatic issue(input logic [15:0] rn, input logic [2:0] sz, input bit t, w, p, input bit expect_go);
    @(negedge clk);
    regno = rn; size = sz; tr = t; wr = w; pe = p; cmd_valid = 1;
    if (expect_go)
      sb_q.push_back({t ? exp_xfer(rn[4:0], sz, w) : 32'h0000_0013, p ? 32'h0000_0013 : 32'h0010_0073});
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic finish_cmd();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
    chk(!busy, "R8 busy clears after done", busy, 0);
  endtask

  task automatic clear_err();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    chk(cmderr == 0, "R12 clear", cmderr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !go && cmderr == 0, "R1 reset ctrl", {busy, go, cmderr}, 0);
    chk(i0 == 32'h13 && i1 == 32'h0010_0073, "R1 reset words", {i0, i1}, {32'h13, 32'h0010_0073});

    issue(16'h1005, 3'd2, 1, 1, 0, 1);   // R2 R4 lw x5, ebreak
    repeat (3) @(negedge clk);
    chk(busy && !go, "R8 busy held without done", {busy, go}, 2'b10);
    finish_cmd();
    issue(16'h101F, 3'd3, 1, 0, 1, 1);   // R3 R4 sd x31, nop
    finish_cmd();
    issue(16'h1001, 3'd4, 1, 1, 0, 1);   // R4 lq x1
    finish_cmd();
    issue(16'h100A, 3'd4, 1, 0, 1, 1);   // R4 sq x10
    finish_cmd();
    issue(16'h1003, 3'd2, 1, 0, 0, 1);   // R3 sw x3
    finish_cmd();
    issue(16'h0000, 3'd7, 0, 1, 0, 1);   // R5 no transfer, bad fields unchecked
    finish_cmd();
    issue(16'h0000, 3'd7, 0, 0, 1, 1);   // R6 postexec nop tail
    finish_cmd();

    // R9 command while busy
    issue(16'h1002, 3'd3, 1, 1, 0, 1);
    issue(16'h1004, 3'd2, 1, 0, 1, 0);
    chk(cmderr == 1, "R9 busy error", cmderr, 1);
    chk(i0 == exp_xfer(5'd2, 3'd3, 1), "R9 words unchanged", i0, exp_xfer(5'd2, 3'd3, 1));
    finish_cmd();
    // R12 ignored while error set
    issue(16'h1004, 3'd2, 1, 1, 0, 0);
    chk(!busy && cmderr == 1, "R12 ignored while error", {busy, cmderr}, {1'b0, 3'd1});
    clear_err();

    // R10 unsupported size and register
    issue(16'h1004, 3'd5, 1, 1, 0, 0);
    chk(!busy && cmderr == 2, "R10 bad size", {busy, cmderr}, {1'b0, 3'd2});
    clear_err();
    issue(16'h1020, 3'd2, 1, 0, 0, 0);
    chk(!busy && cmderr == 2, "R10 bad regno", {busy, cmderr}, {1'b0, 3'd2});
    clear_err();
    issue(16'h1004, 3'd1, 1, 0, 0, 0);
    chk(cmderr == 2, "R10 size below 32", cmderr, 2);
    clear_err();

    // R11 exception
    issue(16'h1006, 3'd2, 1, 1, 0, 1);
    @(negedge clk); exc = 1;
    @(negedge clk); exc = 0;
    chk(cmderr == 3 && busy, "R11 exception", {busy, cmderr}, {1'b1, 3'd3});
    finish_cmd();
    chk(cmderr == 3, "R12 sticky after done", cmderr, 3);
    clear_err();

    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R7 all expected starts seen", sb_q.size(), 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule